// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames into buffer memory under control of a small ring of receive descriptors kept in its own registers. Each descriptor has a 16-bit status word, a length and a buffer index. Software marks a descriptor empty to give it to the engine. It then writes a fixed key to the poll register to start the engine. The engine fills empty descriptors in ring order, one frame per descriptor.

Frames arrive as a byte stream with valid/ready handshaking, an end-of-frame flag and an error flag. Accepted bytes go out on a buffer write port. That port has no back-pressure, so the attached memory must accept a write in every cycle. The stream rules are as follows. A beat transfers when `in_valid` and `in_ready` are both high. `in_ready` is low for exactly one cycle after the last byte of a frame that was stored, while that descriptor is closed, and high at all other times out of reset. A source may hold `in_valid` high across that cycle, and its data then waits. A frame that cannot be stored is still taken at full rate and discarded.

When a frame closes, the engine writes its length and error code into the descriptor and clears the empty bit. It then moves to the next descriptor, or back to descriptor 0 if the closed one carries the wrap bit. If the engine meets a descriptor that software has not returned, it stops and counts an overrun. It starts again only after another poll write.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset, every descriptor has length 0 and buffer index equal to its position. Its status word is 0, except that the last descriptor has the wrap bit (bit 13) set. The overrun count is 0, the current index is 0 and polling is off.
- R2: Polling turns on only when the exact value 0x01000000 is written to the poll register (global field 0). Any other value written there has no effect, and a frame that follows it is dropped.
- R3: When a descriptor closes, the current index returns to 0 if that descriptor's wrap bit is set. Otherwise the index increments.
- R4: A frame is stored when polling is on and the current descriptor's empty bit (bit 15) is set at its first byte. Byte k is written to buffer address {buffer index, k}. At the end of the frame, the length field gets the stored byte count. The empty bit and status bits 5..0 take the new error code, and all other status bits are kept.
- R5: At most 1518 bytes of a frame are written. Extra bytes are consumed without being written. The length field then reads 1518 and status bit 5 is set.
- R6: A frame whose first byte finds polling off, or finds the current descriptor not empty, is consumed with no buffer writes, and the overrun count increases by one. Meeting a non-empty descriptor also turns polling off.
- R7: If `in_err` is high on any byte of a stored frame, status bit 0 of its descriptor is set. Otherwise that bit is cleared.
- R8: `in_ready` is low for exactly the one cycle after the last byte of a stored frame is accepted. It is high in every other cycle.
- R9: A poll write in the same cycle as the first byte of a frame applies to that frame.
- R10: Software can write and read back each descriptor's status (field 0), length (field 1) and buffer index (field 2). A wrap bit that software moves to an earlier descriptor shortens the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Bit 4 = global; else bits 3..2 descriptor, bits 1..0 field. Global fields: 0 poll, 1 overrun count, 2 {polling at bit 8, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte ends the frame |
| in_err | input | 1 | Byte carries an error mark |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 13 | Buffer write address {buffer index, offset} |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The poll write and the first byte of a frame can land in the same cycle. The bench provokes this after polling has stopped: it drives the poll key onto the register port in the very cycle it presents the opening byte. The frame must be stored rather than dropped, with its first byte written at offset 0 and the overrun count unchanged. The same collision is then repeated at random, including cases where the current descriptor is still owned by software, to check that the frame is dropped and polling ends.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ST_EMPTY  = 15;
  localparam int ST_WRAP   = 13;
  localparam int ERR_LONG  = 5;
  localparam int ERR_FRAME = 0;
  localparam logic [15:0] ERR_MASK = 16'h003f;
  localparam logic [31:0] POLL_KEY = 32'h0100_0000;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RECV,
    S_DROP,
    S_CLOSE
  } rx_state_e;
endpackage

// File: rtl/rxr_desc_regs.sv
module rxr_desc_regs
  import rxr_pkg::*;
#(
  parameter int NDESC  = 4,
  parameter int IDX_W  = 2,
  parameter int BIDX_W = 2,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [1:0]        sw_field,
  input  logic [15:0]       sw_data,
  input  logic              close_en,
  input  logic [IDX_W-1:0]  close_idx,
  input  logic [5:0]        close_err,
  input  logic [CNT_W-1:0]  close_len,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              cur_empty,
  output logic              cur_wrap,
  output logic [BIDX_W-1:0] cur_bidx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_field,
  output logic [15:0]       rd_data
);
  localparam logic [15:0] CLOSE_CLR = ERR_MASK | (16'h1 << ST_EMPTY);

  logic [15:0]       st_a   [NDESC];
  logic [CNT_W-1:0]  len_a  [NDESC];
  logic [BIDX_W-1:0] bidx_a [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_desc
    localparam logic [15:0] ST_RST = (g == NDESC - 1) ? (16'h1 << ST_WRAP) : 16'h0;
    logic [15:0]       st_r;
    logic [CNT_W-1:0]  len_r;
    logic [BIDX_W-1:0] bidx_r;
    logic              hit_close, hit_sw;

    assign hit_close = close_en && (close_idx == IDX_W'(g));
    assign hit_sw    = sw_we && (sw_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r   <= ST_RST;
        len_r  <= '0;
        bidx_r <= BIDX_W'(g);
      end else if (hit_close) begin
        st_r  <= (st_r & ~CLOSE_CLR) | {10'b0, close_err};
        len_r <= close_len;
      end else if (hit_sw) begin
        case (sw_field)
          2'd0:    st_r   <= sw_data;
          2'd1:    len_r  <= sw_data[CNT_W-1:0];
          2'd2:    bidx_r <= sw_data[BIDX_W-1:0];
          default: ;
        endcase
      end
    end

    assign st_a[g]   = st_r;
    assign len_a[g]  = len_r;
    assign bidx_a[g] = bidx_r;
  end

  assign cur_empty = st_a[cur_idx][ST_EMPTY];
  assign cur_wrap  = st_a[cur_idx][ST_WRAP];
  assign cur_bidx  = bidx_a[cur_idx];

  always_comb begin
    case (rd_field)
      2'd0:    rd_data = st_a[rd_idx];
      2'd1:    rd_data = 16'(len_a[rd_idx]);
      2'd2:    rd_data = 16'(bidx_a[rd_idx]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
  import rxr_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int BIDX_W    = 2,
  parameter int OFF_W     = 11,
  parameter int CNT_W     = 11,
  parameter int MAX_FRAME = 1518,
  parameter int OVR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  input  logic                    in_err,
  input  logic                    poll_wr,
  input  logic                    cur_empty,
  input  logic                    cur_wrap,
  input  logic [BIDX_W-1:0]       cur_bidx,
  output logic [IDX_W-1:0]        cur_idx,
  output logic                    run,
  output logic [OVR_W-1:0]        ovr_cnt,
  output logic                    idle,
  output logic                    close_en,
  output logic [5:0]              close_err,
  output logic [CNT_W-1:0]        close_len,
  output logic                    buf_we,
  output logic [BIDX_W+OFF_W-1:0] buf_addr,
  output logic [7:0]              buf_wdata
);
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q, long_q;
  logic             beat, start, take, room;

  assign in_ready = (state_q != S_CLOSE);
  assign beat     = in_valid && in_ready;
  assign idle     = (state_q == S_IDLE);
  assign start    = idle && beat;
  assign take     = start && (run || poll_wr) && cur_empty;
  assign room     = (cnt_q < CNT_W'(MAX_FRAME));

  assign buf_we    = (take || (state_q == S_RECV && beat)) && room;
  assign buf_addr  = {cur_bidx, OFF_W'(cnt_q)};
  assign buf_wdata = in_data;

  assign close_en  = (state_q == S_CLOSE);
  assign close_len = cnt_q;
  always_comb begin
    close_err            = '0;
    close_err[ERR_LONG]  = long_q;
    close_err[ERR_FRAME] = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      long_q  <= 1'b0;
      cur_idx <= '0;
      run     <= 1'b0;
      ovr_cnt <= '0;
    end else begin
      if (start)        run <= take;
      else if (poll_wr) run <= 1'b1;

      case (state_q)
        S_IDLE: if (start) begin
          if (take) begin
            cnt_q   <= CNT_W'(1);
            err_q   <= in_err;
            long_q  <= 1'b0;
            state_q <= in_last ? S_CLOSE : S_RECV;
          end else begin
            ovr_cnt <= ovr_cnt + 1'b1;
            state_q <= in_last ? S_IDLE : S_DROP;
          end
        end
        S_RECV: if (beat) begin
          if (room) cnt_q <= cnt_q + 1'b1;
          else      long_q <= 1'b1;
          if (in_err)  err_q   <= 1'b1;
          if (in_last) state_q <= S_CLOSE;
        end
        S_DROP: if (beat && in_last) state_q <= S_IDLE;
        S_CLOSE: begin
          cur_idx <= cur_wrap ? '0 : IDX_W'(cur_idx + 1'b1);
          cnt_q   <= '0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
  import rxr_pkg::*;
#(
  parameter int NDESC     = 4,
  parameter int BIDX_W    = 2,
  parameter int BUF_LIMIT = 1520,
  parameter int MAX_FRAME = 1518,
  parameter int OVR_W     = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        reg_wr,
  input  logic [$clog2(NDESC)+2:0]                    reg_addr,
  input  logic [31:0]                                 reg_wdata,
  output logic [31:0]                                 reg_rdata,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [7:0]                                  in_data,
  input  logic                                        in_last,
  input  logic                                        in_err,
  output logic                                        buf_we,
  output logic [BIDX_W+$clog2(BUF_LIMIT)-1:0]         buf_addr,
  output logic [7:0]                                  buf_wdata
);
  localparam int IDX_W  = $clog2(NDESC);
  localparam int OFF_W  = $clog2(BUF_LIMIT);
  localparam int CNT_W  = $clog2(MAX_FRAME + 1);
  localparam int ADDR_W = IDX_W + 3;

  logic              glob, poll_wr, sw_we;
  logic [1:0]        fld;
  logic [IDX_W-1:0]  didx, cur_idx;
  logic              cur_empty, cur_wrap, run, idle, close_en;
  logic [BIDX_W-1:0] cur_bidx;
  logic [OVR_W-1:0]  ovr_cnt;
  logic [5:0]        close_err;
  logic [CNT_W-1:0]  close_len;
  logic [15:0]       desc_rd;

  assign glob    = reg_addr[ADDR_W-1];
  assign fld     = reg_addr[1:0];
  assign didx    = reg_addr[IDX_W+1:2];
  assign sw_we   = reg_wr && !glob && (fld != 2'd3);
  assign poll_wr = reg_wr && glob && (fld == 2'd0) && (reg_wdata == POLL_KEY);

  rxr_desc_regs #(
    .NDESC(NDESC), .IDX_W(IDX_W), .BIDX_W(BIDX_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk, .rst_n,
    .sw_we, .sw_idx(didx), .sw_field(fld), .sw_data(reg_wdata[15:0]),
    .close_en, .close_idx(cur_idx), .close_err, .close_len,
    .cur_idx, .cur_empty, .cur_wrap, .cur_bidx,
    .rd_idx(didx), .rd_field(fld), .rd_data(desc_rd)
  );

  rxr_frame_ctl #(
    .IDX_W(IDX_W), .BIDX_W(BIDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W),
    .MAX_FRAME(MAX_FRAME), .OVR_W(OVR_W)
  ) u_ctl (
    .clk, .rst_n,
    .in_valid, .in_ready, .in_data, .in_last, .in_err,
    .poll_wr, .cur_empty, .cur_wrap, .cur_bidx,
    .cur_idx, .run, .ovr_cnt, .idle,
    .close_en, .close_err, .close_len,
    .buf_we, .buf_addr, .buf_wdata
  );

  always_comb begin
    reg_rdata = '0;
    if (!glob) begin
      reg_rdata[15:0] = desc_rd;
    end else if (fld == 2'd1) begin
      reg_rdata[OVR_W-1:0] = ovr_cnt;
    end else if (fld == 2'd2) begin
      reg_rdata[8]         = run;
      reg_rdata[IDX_W-1:0] = cur_idx;
    end
  end
endmodule

// File: rtl/rxr_ring_checks.sv
module rxr_ring_checks #(
  parameter int IDX_W     = 2,
  parameter int OFF_W     = 11,
  parameter int AW        = 13,
  parameter int MAX_FRAME = 1518,
  parameter int OVR_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             buf_we,
  input logic [AW-1:0]    buf_addr,
  input logic             close_en,
  input logic             cur_wrap,
  input logic             cur_empty,
  input logic             idle,
  input logic [IDX_W-1:0] cur_idx,
  input logic [OVR_W-1:0] ovr_cnt
);
  AST_STORE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (in_valid && in_ready)); // R4
  AST_OFFSET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(buf_addr[OFF_W-1:0]) < MAX_FRAME)); // R5
  AST_WRAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && cur_wrap) |=> (cur_idx == '0)); // R3
  AST_STEP_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && !cur_wrap) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1))); // R3
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_cnt) |-> (ovr_cnt == OVR_W'($past(ovr_cnt) + 1'b1))); // R6
  AST_FULL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_valid && !cur_empty) |-> !buf_we); // R6
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |=> in_ready); // R8
endmodule

bind rxr_ring_engine rxr_ring_checks #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .AW(BIDX_W + OFF_W),
  .MAX_FRAME(MAX_FRAME), .OVR_W(OVR_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .buf_we(buf_we), .buf_addr(buf_addr), .close_en(close_en),
  .cur_wrap(cur_wrap), .cur_empty(cur_empty), .idle(idle),
  .cur_idx(cur_idx), .ovr_cnt(ovr_cnt)
);

// File: tb/rxr_ring_engine_test.sv
`timescale 1ns/1ps
module rxr_ring_engine_test;
  localparam int N   = 4;
  localparam int MAX = 1518;
  localparam logic [15:0] EMP = 16'h8000;
  localparam logic [15:0] WRP = 16'h2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0, buf_wdata;
  logic buf_we;
  logic [12:0] buf_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [15:0] m_st [N];
  int m_len [N], m_bidx [N];
  int m_idx = 0, m_ovr = 0;
  bit m_run = 1'b0;

  always #5 clk = ~clk;

  rxr_ring_engine uut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .in_valid, .in_ready, .in_data, .in_last, .in_err,
    .buf_we, .buf_addr, .buf_wdata
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] closed_status(logic [15:0] old, bit err, bit lng);
    return (old & ~(EMP | 16'h003f)) | {10'b0, lng, 4'b0, err};
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [4:0] daddr(int i, int f);
    return {1'b0, 2'(i), 2'(f)};
  endfunction

  task automatic sw_desc(input int i, input logic [15:0] st);
    reg_write(daddr(i, 0), {16'h0, st});
    m_st[i] = st;
  endtask

  task automatic poll();
    reg_write(5'h10, 32'h0100_0000);
    m_run = 1'b1;
  endtask

  // one frame; err_at < 0 means no error mark; with_poll drives the key on byte 0
  task automatic send_frame(input int len, input int err_at, input bit with_poll);
    bit acc, lng;
    int bad = 0, idx;
    logic [31:0] rd;
    idx = m_idx;
    acc = (m_run || with_poll) && m_st[idx][15];
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      in_valid = 1'b1; in_data = 8'($urandom); in_last = (k == len - 1);
      in_err = (k == err_at);
      if (k == 0 && with_poll) begin
        reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h0100_0000;
      end
      #1;
      if (buf_we !== (acc && k < MAX)) bad++;
      else if (buf_we && (buf_addr !== {2'(m_bidx[idx]), 11'(k)} || buf_wdata !== in_data)) bad++;
      @(posedge clk);
      #1 reg_wr = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    if (acc) chk(in_ready == 1'b0, "R8 ready low after last", in_ready, 0);
    chk(bad == 0, acc ? "R4 buffer writes" : "R6 no writes on drop", bad, 0);
    if (acc) begin
      lng = (len > MAX);
      m_st[idx]  = closed_status(m_st[idx], err_at >= 0, lng);
      m_len[idx] = lng ? MAX : len;
      m_idx      = m_st[idx][13] ? 0 : (idx + 1) % N;
      m_run      = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 ready back", in_ready, 1);
      reg_read(daddr(idx, 0), rd);
      chk(rd[15:0] == m_st[idx], "R4 R7 status", rd[15:0], m_st[idx]);
      reg_read(daddr(idx, 1), rd);
      chk(rd == m_len[idx], "R4 R5 length", rd, m_len[idx]);
    end else begin
      m_ovr++;
      m_run = 1'b0;
    end
    reg_read(5'h11, rd);
    chk(rd == (m_ovr % 256), "R6 overrun count", rd, m_ovr % 256);
    reg_read(5'h12, rd);
    chk(rd == ({m_run, 8'(m_idx)}), "R3 R6 index and polling", rd, {m_run, 8'(m_idx)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_st[i] = (i == N - 1) ? WRP : 16'h0; m_len[i] = 0; m_bidx[i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < N; i++) begin
      reg_read(daddr(i, 0), rd); chk(rd == m_st[i], "R1 status", rd, m_st[i]);
      reg_read(daddr(i, 1), rd); chk(rd == 0, "R1 length", rd, 0);
      reg_read(daddr(i, 2), rd); chk(rd == i, "R1 buffer index", rd, i);
    end
    reg_read(5'h11, rd); chk(rd == 0, "R1 overrun", rd, 0);
    reg_read(5'h12, rd); chk(rd == 0, "R1 index/polling", rd, 0);
    chk(in_ready == 1'b1, "R1 R8 ready", in_ready, 1);

    // R10 software fields
    for (int i = 0; i < N; i++) sw_desc(i, EMP | ((i == N - 1) ? WRP : 16'h0));
    reg_write(daddr(2, 2), 32'h3); m_bidx[2] = 3;
    reg_write(daddr(3, 2), 32'h2); m_bidx[3] = 2;
    reg_read(daddr(2, 2), rd); chk(rd == 3, "R10 buffer index readback", rd, 3);
    reg_read(daddr(3, 0), rd); chk(rd == (EMP | WRP), "R10 status readback", rd, EMP | WRP);
    reg_write(daddr(1, 1), 32'h55); m_len[1] = 'h55;
    reg_read(daddr(1, 1), rd); chk(rd == 'h55, "R10 length readback", rd, 'h55);

    // R2 wrong key ignored
    reg_write(5'h10, 32'h0000_0001);
    reg_read(5'h12, rd); chk(rd[8] == 1'b0, "R2 wrong key no poll", rd[8], 0);
    send_frame(5, -1, 1'b0);

    // R2 R4 R7 R3: fill ring and wrap
    poll();
    send_frame(10, -1, 1'b0);
    send_frame(7, 3, 1'b0);
    send_frame(1, 0, 1'b0);
    send_frame(20, -1, 1'b0);
    chk(m_idx == 0, "R3 wrapped model", m_idx, 0);

    // R6 non-empty descriptor stops polling
    send_frame(6, -1, 1'b0);
    for (int i = 0; i < N; i++) sw_desc(i, EMP | (m_st[i] & WRP));
    send_frame(4, -1, 1'b0);     // polling off: dropped
    // R9 key in the same cycle as the first byte
    send_frame(9, -1, 1'b1);

    // R10 shortened ring via wrap on descriptor 1
    sw_desc(1, EMP | WRP);
    send_frame(3, -1, 1'b0);
    chk(m_idx == 0, "R10 short ring return", m_idx, 0);
    sw_desc(1, m_st[1] & ~WRP);
    sw_desc(0, EMP);

    // R5 oversize frame
    send_frame(MAX + 12, -1, 1'b0);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int len, ea;
      for (int i = 0; i < N; i++)
        if ($urandom % 4 != 0 && !m_st[i][15]) sw_desc(i, EMP | (m_st[i] & WRP));
      len = 1 + ($urandom % 40);
      ea  = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      case ($urandom % 4)
        0: send_frame(len, ea, 1'b1);
        1: begin poll(); send_frame(len, ea, 1'b0); end
        default: send_frame(len, ea, 1'b0);
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule